// File: doc/BRIEF.md
# Floating-Point Multiply Special-Operand Resolver

This block sits at the head of a double-precision multiply. It sorts each operand into one of five classes (zero, finite, infinity, quiet NaN, signaling NaN). From the two classes it decides whether the product is already fixed without any significand arithmetic. A fixed product is a NaN, an infinity, a signed zero, or an invalid operation. When the product is fixed, the block drives the final result word and the invalid status on the same cycle. When both operands are finite and nonzero, subnormals included, it raises a pass signal and the downstream multiply datapath produces the result.

The logic is purely combinational. NaN handling depends on operand order: the first operand is resolved completely before the second operand's special classes are looked at. A signaling NaN is never returned as is. It is quieted by inverting the top fraction bit. If that leaves the fraction all zero, the next fraction bit is set so that the word stays a NaN. A parameter chooses which value of the top fraction bit marks a signaling NaN. When invalid operations trap, the block requests the trap and drives an all-zero result with no flag, so the environment writes nothing.

Top module: `fpm_special_resolve`

## Requirements
- R1: The sign of every infinity or zero result equals the XOR of the two operand sign bits. The operand word holds the sign in its top bit, the biased exponent in the next EXP_W bits and the fraction in the low FRAC_W bits.
- R2: If the first operand is a NaN, the second operand's class matters only in one case: the first NaN is quiet and the second is signaling.
- R3: Infinity times zero, in either order, with the trap disabled, sets invalid_o and returns the default NaN: sign 0, exponent all ones, fraction top bit equal to the quiet value and the bit below it equal to SNAN_MSB_HI.
- R4: Infinity times an operand that is neither NaN nor zero returns exponent all ones and fraction zero.
- R5: A signaling NaN in the first operand sets invalid_o and returns that operand quieted.
- R6: If the first operand is a quiet NaN, a signaling second NaN is returned quieted with invalid_o set. Otherwise the first operand is returned bit for bit with invalid_o clear.
- R7: If the second operand is a NaN and the first is not, the second is returned. A quiet NaN is returned unchanged with no flag. A signaling NaN is returned quieted with invalid_o set. This holds even when the first operand is infinity.
- R8: A zero operand (exponent 0, fraction 0) with a non-NaN, non-infinite partner returns a signed zero.
- R9: pass_o is 1 exactly when both operands are finite and nonzero, subnormals included. With pass_o at 1, result_o is all zero and both invalid outputs are 0.
- R10: With SNAN_MSB_HI=1, a NaN with fraction top bit 1 is signaling. With SNAN_MSB_HI=0, a NaN with that bit 0 is signaling. Quieting inverts the top bit and sets the bit below it if the fraction would otherwise be zero.
- R11: Any invalid case with inv_trap_en_i=1 gives inv_trap_o=1, invalid_o=0, pass_o=0 and result_o all zero. inv_trap_o is never 1 when the trap is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 1+EXP_W+FRAC_W | First operand (sets NaN priority) |
| opb_i | input | 1+EXP_W+FRAC_W | Second operand |
| inv_trap_en_i | input | 1 | Invalid operations trap instead of flagging |
| result_o | output | 1+EXP_W+FRAC_W | Resolved product, zero when passing or trapping |
| invalid_o | output | 1 | Invalid flag for a non-trapping invalid case |
| inv_trap_o | output | 1 | Invalid trap request |
| pass_o | output | 1 | Operands go to the finite multiply path |

## Verification
The checker evaluates on every input change the rules that relate outputs to each other and to the operand classes. It checks that pass_o and trap requests are exclusive of any result or flag, that a flag appears only when the trap is disabled, and that a NaN operand never passes. It also checks that every NaN output is quiet and that infinity and zero results carry the XOR sign. Operand-order priority is left to the bench, as are the exact quieted fraction, the default NaN pattern and the subnormal pass-through. The bench sweeps every operand pair and trap setting of a 3-bit-exponent, 3-bit-fraction configuration under both signaling polarities.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    CL_ZERO   = 3'd0,
    CL_FINITE = 3'd1,
    CL_INF    = 3'd2,
    CL_QNAN   = 3'd3,
    CL_SNAN   = 3'd4
  } opclass_e;

endpackage

// File: rtl/fpm_opclass.sv
module fpm_opclass
  import fpm_pkg::*;
#(
  parameter int EXP_W       = 11,
  parameter int FRAC_W      = 52,
  parameter bit SNAN_MSB_HI = 1'b1
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  output opclass_e              cls_o
);

  logic [EXP_W-1:0]  exp_fld;
  logic [FRAC_W-1:0] frac_fld;
  logic              exp_max, exp_min, frac_nil;

  assign exp_fld  = word_i[FRAC_W +: EXP_W];
  assign frac_fld = word_i[FRAC_W-1:0];
  assign exp_max  = &exp_fld;
  assign exp_min  = ~|exp_fld;
  assign frac_nil = ~|frac_fld;

  always_comb begin
    if (exp_max && frac_nil)
      cls_o = CL_INF;
    else if (exp_max)
      cls_o = (frac_fld[FRAC_W-1] == SNAN_MSB_HI) ? CL_SNAN : CL_QNAN;
    else if (exp_min && frac_nil)
      cls_o = CL_ZERO;
    else
      cls_o = CL_FINITE;
  end

endmodule

// File: rtl/fpm_nan_quiet.sv
module fpm_nan_quiet #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] nan_i,
  output logic [EXP_W+FRAC_W:0] quiet_o
);

  logic [FRAC_W-1:0] flipped;

  always_comb begin
    flipped = nan_i[FRAC_W-1:0];
    flipped[FRAC_W-1] = ~nan_i[FRAC_W-1];
    if (flipped == '0)
      flipped[FRAC_W-2] = 1'b1;
    quiet_o = {nan_i[EXP_W+FRAC_W:FRAC_W], flipped};
  end

endmodule

// File: rtl/fpm_special_resolve.sv
module fpm_special_resolve
  import fpm_pkg::*;
#(
  parameter int EXP_W       = 11,
  parameter int FRAC_W      = 52,
  parameter bit SNAN_MSB_HI = 1'b1
) (
  input  logic [EXP_W+FRAC_W:0] opa_i,
  input  logic [EXP_W+FRAC_W:0] opb_i,
  input  logic                  inv_trap_en_i,
  output logic [EXP_W+FRAC_W:0] result_o,
  output logic                  invalid_o,
  output logic                  inv_trap_o,
  output logic                  pass_o
);

  localparam int W = 1 + EXP_W + FRAC_W;

  opclass_e       cls   [2];
  logic [W-1:0]   word  [2];
  logic [W-1:0]   quiet [2];

  assign word[0] = opa_i;
  assign word[1] = opb_i;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    fpm_opclass #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .SNAN_MSB_HI(SNAN_MSB_HI)
    ) u_cls (
      .word_i(word[g]),
      .cls_o (cls[g])
    );
    fpm_nan_quiet #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W)
    ) u_quiet (
      .nan_i  (word[g]),
      .quiet_o(quiet[g])
    );
  end

  logic              prod_sign;
  logic [FRAC_W-1:0] dflt_frac;
  logic [W-1:0]      inf_word, zero_word, dflt_nan;
  logic [W-1:0]      res_pick;
  logic              bad_op, a_nan, b_nan;

  assign prod_sign = opa_i[W-1] ^ opb_i[W-1];
  assign inf_word  = {prod_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  assign zero_word = {prod_sign, {(W-1){1'b0}}};

  always_comb begin
    dflt_frac = '0;
    dflt_frac[FRAC_W-1] = ~SNAN_MSB_HI;
    dflt_frac[FRAC_W-2] = SNAN_MSB_HI;
  end
  assign dflt_nan = {1'b0, {EXP_W{1'b1}}, dflt_frac};

  assign a_nan = (cls[0] == CL_QNAN) || (cls[0] == CL_SNAN);
  assign b_nan = (cls[1] == CL_QNAN) || (cls[1] == CL_SNAN);

  // Priority chain: first operand resolved before the second.
  always_comb begin
    res_pick = '0;
    bad_op   = 1'b0;
    pass_o   = 1'b0;
    if (cls[0] == CL_INF && !b_nan) begin
      if (cls[1] == CL_ZERO) begin
        bad_op   = 1'b1;
        res_pick = dflt_nan;
      end else begin
        res_pick = inf_word;
      end
    end else if (a_nan) begin
      if (cls[0] == CL_SNAN) begin
        bad_op   = 1'b1;
        res_pick = quiet[0];
      end else if (cls[1] == CL_SNAN) begin
        bad_op   = 1'b1;
        res_pick = quiet[1];
      end else begin
        res_pick = opa_i;
      end
    end else if (cls[1] == CL_INF) begin
      if (cls[0] == CL_ZERO) begin
        bad_op   = 1'b1;
        res_pick = dflt_nan;
      end else begin
        res_pick = inf_word;
      end
    end else if (b_nan) begin
      if (cls[1] == CL_SNAN) begin
        bad_op   = 1'b1;
        res_pick = quiet[1];
      end else begin
        res_pick = opb_i;
      end
    end else if (cls[0] == CL_ZERO || cls[1] == CL_ZERO) begin
      res_pick = zero_word;
    end else begin
      pass_o = 1'b1;
    end
  end

  assign inv_trap_o = bad_op & inv_trap_en_i;
  assign invalid_o  = bad_op & ~inv_trap_en_i;
  assign result_o   = inv_trap_o ? '0 : res_pick;

endmodule

// File: rtl/fpm_special_resolve_chk.sv
module fpm_special_resolve_chk #(
  parameter int EXP_W       = 11,
  parameter int FRAC_W      = 52,
  parameter bit SNAN_MSB_HI = 1'b1
) (
  input logic [EXP_W+FRAC_W:0] opa_i,
  input logic [EXP_W+FRAC_W:0] opb_i,
  input logic                  inv_trap_en_i,
  input logic [EXP_W+FRAC_W:0] result_o,
  input logic                  invalid_o,
  input logic                  inv_trap_o,
  input logic                  pass_o
);

  localparam int W = 1 + EXP_W + FRAC_W;

  function automatic logic is_nan(input logic [W-1:0] x);
    return (&x[FRAC_W +: EXP_W]) && (|x[FRAC_W-1:0]);
  endfunction

  logic res_inf, res_zero, sgn;
  assign res_inf  = (&result_o[FRAC_W +: EXP_W]) && ~|result_o[FRAC_W-1:0];
  assign res_zero = ~|result_o[W-2:0];
  assign sgn      = opa_i[W-1] ^ opb_i[W-1];

  always_comb begin
    p_pass_clean_r9: assert (!pass_o || (!invalid_o && !inv_trap_o && result_o == '0));
    p_trap_clean_r11: assert (!inv_trap_o || (!invalid_o && !pass_o && result_o == '0));
    p_trap_needs_en_r11: assert (!inv_trap_o || inv_trap_en_i);
    p_flag_needs_dis_r3: assert (!invalid_o || !inv_trap_en_i);
    p_nan_never_passes_r2: assert (!(is_nan(opa_i) || is_nan(opb_i)) || (!pass_o && (inv_trap_o || is_nan(result_o))));
    p_nan_out_quiet_r10: assert (!is_nan(result_o) || result_o[FRAC_W-1] != SNAN_MSB_HI);
    p_inf_sign_r1: assert (!res_inf || result_o[W-1] == sgn);
    p_zero_sign_r8: assert (!(res_zero && !pass_o && !inv_trap_o) || result_o[W-1] == sgn);
  end

endmodule

bind fpm_special_resolve fpm_special_resolve_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .SNAN_MSB_HI(SNAN_MSB_HI)
) u_chk (.*);

// File: tb/tb_fpm_special_resolve.sv
`timescale 1ns/1ps
module tb_fpm_special_resolve;

  localparam int EW = 3;
  localparam int FW = 3;
  localparam int W  = 1 + EW + FW;

  logic clk, rst_n;
  logic [W-1:0] opa, opb;
  logic         ten;
  logic [W-1:0] res_h, res_l;
  logic         inv_h, inv_l, trp_h, trp_l, pas_h, pas_l;
  int           n_vec, n_bad;
  bit           done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  fpm_special_resolve #(.EXP_W(EW), .FRAC_W(FW), .SNAN_MSB_HI(1'b1)) dut (
    .opa_i(opa), .opb_i(opb), .inv_trap_en_i(ten),
    .result_o(res_h), .invalid_o(inv_h), .inv_trap_o(trp_h), .pass_o(pas_h));

  fpm_special_resolve #(.EXP_W(EW), .FRAC_W(FW), .SNAN_MSB_HI(1'b0)) dut_lo (
    .opa_i(opa), .opb_i(opb), .inv_trap_en_i(ten),
    .result_o(res_l), .invalid_o(inv_l), .inv_trap_o(trp_l), .pass_o(pas_l));

  // Reference built from the requirement text.
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit en, input bit hi,
                       output logic [W-1:0] r, output bit iv, output bit tp,
                       output bit ps, output string tag);
    bit an, bn, as, bs, ai, bi, az, bz;
    logic [FW-1:0] qa, qb;
    an = (a[5:3] == 3'b111) && (a[2:0] != 0);
    bn = (b[5:3] == 3'b111) && (b[2:0] != 0);
    as = an && (a[2] == hi);            // R10 polarity
    bs = bn && (b[2] == hi);
    ai = (a[5:3] == 3'b111) && (a[2:0] == 0);
    bi = (b[5:3] == 3'b111) && (b[2:0] == 0);
    az = (a[5:0] == 0);
    bz = (b[5:0] == 0);
    qa = a[2:0] ^ 3'b100; if (qa == 0) qa = 3'b010;
    qb = b[2:0] ^ 3'b100; if (qb == 0) qb = 3'b010;
    r = '0; iv = 0; tp = 0; ps = 0;
    if (an) begin
      tag = bn ? "R2" : "R5";
      if (as) begin r = {a[6:3], qa}; iv = 1; end
      else if (bs) begin r = {b[6:3], qb}; iv = 1; tag = "R6"; end
      else begin r = a; if (!bn) tag = "R6"; end
    end else if (bn) begin
      tag = "R7";
      if (bs) begin r = {b[6:3], qb}; iv = 1; end
      else r = b;
    end else if (ai || bi) begin
      if (az || bz) begin
        tag = "R3"; iv = 1;
        r = hi ? 7'b0111010 : 7'b0111100;
      end else begin
        tag = "R4,R1"; r = {a[6] ^ b[6], 6'b111000};
      end
    end else if (az || bz) begin
      tag = "R8,R1"; r = {a[6] ^ b[6], 6'b000000};
    end else begin
      tag = "R9"; ps = 1;
    end
    if (iv && en) begin
      tag = "R11"; iv = 0; tp = 1; r = '0;
    end
  endtask

  task automatic compare(input string who, input string tag,
                         input logic [W-1:0] ar, input bit ai, input bit at, input bit ap,
                         input logic [W-1:0] er, input bit ei, input bit et, input bit ep);
    n_vec++;
    if (ar !== er || ai !== ei || at !== et || ap !== ep) begin
      n_bad++;
      $display("FAIL %s %s a=%b b=%b en=%0b: got r=%b inv=%0b trap=%0b pass=%0b exp r=%b inv=%0b trap=%0b pass=%0b",
               tag, who, opa, opb, ten, ar, ai, at, ap, er, ei, et, ep);
    end
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; opa = '0; opb = '0; ten = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int e = 0; e < 2; e++) begin
      for (int i = 0; i < (1 << W); i++) begin
        for (int j = 0; j < (1 << W); j++) begin
          logic [W-1:0] er; bit ei, et, ep; string tg;
          @(negedge clk);
          opa = i[W-1:0]; opb = j[W-1:0]; ten = e[0];
          @(posedge clk);
          model(opa, opb, ten, 1'b1, er, ei, et, ep, tg);
          compare("hi", tg, res_h, inv_h, trp_h, pas_h, er, ei, et, ep);
          model(opa, opb, ten, 1'b0, er, ei, et, ep, tg);
          compare("lo", tg, res_l, inv_l, trp_l, pas_l, er, ei, et, ep);
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running, exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule